// File: doc/BRIEF.md
# I2C Master Controller Register Front-End

This block is the software-facing side of an I2C master. It holds five 8-bit registers: own address, clock divider, control, status and data. It turns accesses to them into byte-level commands on a transaction port. The port carries four operations: open with an address byte, send a byte, receive a byte, and end the transfer. Each operation finishes with an ack/nack result. The bit-level engine that drives SCL and SDA sits behind this port and is not part of the block.

The block tracks whether an address phase is currently open. The first data-register write while nothing is open becomes the address byte. Later writes send payload. Data-register reads fetch bytes from the bus. The block maintains the busy, receive-acknowledge, arbitration-lost and interrupt flags and drives one interrupt line. Clearing the enable bit performs a soft reset that keeps the own-address register.

The register interface handles one access at a time. `req_ready_o` stays low while a bus command is outstanding. Reads answer through a one-cycle `rsp_valid_o` pulse.

Top module: `i2c_master_regs`

## Requirements
- R1: The register offsets are 0x00 own address, 0x04 divider, 0x08 control, 0x0C status and 0x10 data. Any other offset reads 0 and ignores writes. All registers reset to 0. A read that issues no bus command answers with `rsp_valid_o` in the cycle after it is accepted.
- R2: Writing the control register with bit 7 (enable) at 0 while enable is 1 is a soft reset. Divider, control, status, the stored receive byte and the open-address state all return to 0, and the own-address value is kept. If an address was open, an end command (op 3) is issued.
- R3: The interrupt flag (status bit 1) is set, and `irq_o` rises, only when control bit 7 (enable) and bit 6 (interrupt enable) are both 1 at the moment a command completes.
- R4: Writing 0 to status bit 1 (interrupt) or bit 4 (arbitration lost) clears that bit. Writing 1 leaves it unchanged. `irq_o` follows status bit 1. The arbitration-lost bit is set when a completion reports `bus_lost_i`.
- R5: A control write that is not a soft reset and has bit 5 (master) set sets status bit 5 (busy). With bit 5 clear, the write clears busy and, if an address is open, issues an end command and closes it.
- R6: A control write with bits 5 and 2 (repeated start) set while an address is open issues an end command, closes the address and reads back with bit 2 cleared. With no address open, bit 2 is stored as written.
- R7: With enable and master set and no address open, a data write issues a start command (op 0) carrying the written byte (bits 7:1 target, bit 0 direction). A nack sets status bit 0 (receive-ack). An ack clears bit 0, opens the address and raises the interrupt.
- R8: With an address open, a data write issues a send command (op 1). An ack clears status bit 0 and raises the interrupt. A nack sets bit 0, closes the address and is followed by an end command, with no interrupt.
- R9: A data read in master mode, with an address open and control bit 4 (transmit) clear, issues a receive command (op 2). It answers with the received byte and raises the interrupt. In master mode otherwise it answers 0xFF and issues nothing. Outside master mode it answers the last stored byte.
- R10: Data writes while enable is 0 issue no bus command and leave status unchanged.
- R11: Every bus command is a single-cycle `bus_valid_o` pulse. `req_ready_o` is low from acceptance until the matching `bus_done_i`, including any end command that follows automatically.
- R12: Only bits 7:0 of a written word are used. Own address stores bits 7:1 (bit 0 reads 0), the divider stores bits 5:0, and control stores bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset of the register |
| req_wdata_i | input | BUS_W | Write data |
| req_ready_o | output | 1 | Access accepted when high with valid |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | BUS_W | Read data, upper bits zero |
| bus_valid_o | output | 1 | Bus command pulse |
| bus_op_o | output | 2 | 0 start, 1 send, 2 receive, 3 end |
| bus_byte_o | output | 8 | Address or data byte for start/send |
| bus_done_i | input | 1 | Command completion pulse |
| bus_ack_i | input | 1 | 1 = ack, 0 = nack |
| bus_lost_i | input | 1 | Arbitration lost during the command |
| bus_rdata_i | input | 8 | Received byte, valid with done |
| irq_o | output | 1 | Interrupt line |

## Verification
A register write takes effect at the clock edge that accepts it. A plain read answers with `rsp_valid_o` one edge later. A bus command leaves one edge after acceptance. Flags and the receive answer follow one edge after `bus_done_i`, and an automatic end command starts on that same edge. The bench drives inputs and samples outputs on falling edges. The read scoreboard insists that a plain read's answer is present at the first falling edge after acceptance. Bus commands and later answers are matched in order against queued expectations whenever they appear, and flag checks are taken only after `req_ready_o` shows the outstanding command has closed.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  localparam int unsigned REG_W = 8;

  localparam int unsigned OFS_OWN  = 'h00;
  localparam int unsigned OFS_DIV  = 'h04;
  localparam int unsigned OFS_CTRL = 'h08;
  localparam int unsigned OFS_STS  = 'h0C;
  localparam int unsigned OFS_DATA = 'h10;

  localparam int unsigned CB_EN   = 7;
  localparam int unsigned CB_IEN  = 6;
  localparam int unsigned CB_MST  = 5;
  localparam int unsigned CB_TX   = 4;
  localparam int unsigned CB_TXAK = 3;
  localparam int unsigned CB_RSTA = 2;

  localparam int unsigned SB_BUSY = 5;
  localparam int unsigned SB_AL   = 4;
  localparam int unsigned SB_IRQ  = 1;
  localparam int unsigned SB_RXAK = 0;

  localparam logic [REG_W-1:0] OWN_MASK  = 8'hFE;
  localparam logic [REG_W-1:0] DIV_MASK  = 8'h3F;
  localparam logic [REG_W-1:0] CTRL_MASK = 8'hFC;
endpackage

// File: rtl/i2cm_xfer.sv
module i2cm_xfer
  import i2cm_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  bus_op_e           launch_op_i,
  input  logic [BYTE_W-1:0] launch_byte_i,
  output logic              bus_valid_o,
  output bus_op_e           bus_op_o,
  output logic [BYTE_W-1:0] bus_byte_o,
  input  logic              bus_done_i,
  input  logic              bus_ack_i,
  input  logic [BYTE_W-1:0] bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output bus_op_e           done_op_o,
  output logic              done_ack_o,
  output logic [BYTE_W-1:0] done_data_o
);
  logic              busy_q, valid_q, auto_q;
  bus_op_e           op_q;
  logic [BYTE_W-1:0] byte_q;

  // a nacked send chains an end command without releasing the port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      auto_q  <= 1'b0;
      op_q    <= OP_START;
      byte_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (launch_i && !busy_q) begin
        busy_q  <= 1'b1;
        valid_q <= 1'b1;
        auto_q  <= 1'b0;
        op_q    <= launch_op_i;
        byte_q  <= launch_byte_i;
      end else if (busy_q && bus_done_i) begin
        if (op_q == OP_SEND && !bus_ack_i && !auto_q) begin
          op_q    <= OP_STOP;
          valid_q <= 1'b1;
          auto_q  <= 1'b1;
        end else begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign bus_valid_o = valid_q;
  assign bus_op_o    = op_q;
  assign bus_byte_o  = byte_q;
  assign busy_o      = busy_q;
  assign done_o      = busy_q && bus_done_i && !auto_q;
  assign done_op_o   = op_q;
  assign done_ack_o  = bus_ack_i;
  assign done_data_o = bus_rdata_i;

  assert_valid_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |=> !bus_valid_o);
  assert_launch_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_q);
  assert_nack_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_SEND && !bus_ack_i) |=> (bus_valid_o && bus_op_o == OP_STOP));
endmodule

// File: rtl/i2cm_status.sv
module i2cm_status
  import i2cm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             en_i,
  input  logic             ien_i,
  input  logic             raise_i,
  input  logic             busy_set_i,
  input  logic             busy_clr_i,
  input  logic             rxak_set_i,
  input  logic             rxak_clr_i,
  input  logic             lost_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] status_o,
  output logic             irq_o
);
  logic busy_q, al_q, irq_q, rxak_q;
  logic unused_wd;
  assign unused_wd = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      al_q   <= 1'b0;
      irq_q  <= 1'b0;
      rxak_q <= 1'b0;
    end else if (soft_rst_i) begin
      busy_q <= 1'b0;
      al_q   <= 1'b0;
      irq_q  <= 1'b0;
      rxak_q <= 1'b0;
    end else begin
      if (busy_set_i)      busy_q <= 1'b1;
      else if (busy_clr_i) busy_q <= 1'b0;
      if (rxak_set_i)      rxak_q <= 1'b1;
      else if (rxak_clr_i) rxak_q <= 1'b0;
      if (lost_i)                          al_q <= 1'b1;
      else if (wr_i && !wdata_i[SB_AL])    al_q <= 1'b0;
      if (raise_i && en_i && ien_i)        irq_q <= 1'b1;
      else if (wr_i && !wdata_i[SB_IRQ])   irq_q <= 1'b0;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[SB_BUSY] = busy_q;
    status_o[SB_AL]   = al_q;
    status_o[SB_IRQ]  = irq_q;
    status_o[SB_RXAK] = rxak_q;
  end
  assign irq_o = irq_q;

  assert_irq_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(en_i && ien_i && raise_i));
  assert_irq_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[SB_IRQ]) |=> !irq_o);
  assert_irq_w1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[SB_IRQ] && irq_q && !soft_rst_i) |=> irq_o);
  assert_al_w1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[SB_AL] && al_q && !soft_rst_i) |=> al_q);
endmodule

// File: rtl/i2c_master_regs.sv
module i2c_master_regs
  import i2cm_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BUS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BUS_W-1:0]  req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [BUS_W-1:0]  rsp_rdata_o,
  output logic              bus_valid_o,
  output logic [1:0]        bus_op_o,
  output logic [7:0]        bus_byte_o,
  input  logic              bus_done_i,
  input  logic              bus_ack_i,
  input  logic              bus_lost_i,
  input  logic [7:0]        bus_rdata_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFS_OWN);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFS_DIV);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  logic [REG_W-1:0] own_q, div_q, ctrl_q, rdata_q, rsp_q, rd_mux, sts;
  logic             addr_open_q, rsp_valid_q;
  logic             x_busy, x_done, x_ack;
  bus_op_e          x_op, x_done_op;
  logic [REG_W-1:0] x_byte, x_data;
  logic             launch;
  bus_op_e          launch_op;
  logic [REG_W-1:0] launch_byte;

  logic unused_hi;
  assign unused_hi = ^req_wdata_i[BUS_W-1:REG_W];

  logic [REG_W-1:0] wbyte;
  logic acc, wr_acc, rd_acc;
  logic sel_own, sel_div, sel_ctrl, sel_sts, sel_data;
  logic soft_rst, ctrl_norm, recv_launch, rsta_close;
  logic done_addr, done_send, done_recv;

  assign req_ready_o = !x_busy;
  assign acc    = req_valid_i && req_ready_o;
  assign wr_acc = acc && req_write_i;
  assign rd_acc = acc && !req_write_i;
  assign wbyte  = req_wdata_i[REG_W-1:0];

  assign sel_own  = (req_addr_i == A_OWN);
  assign sel_div  = (req_addr_i == A_DIV);
  assign sel_ctrl = (req_addr_i == A_CTRL);
  assign sel_sts  = (req_addr_i == A_STS);
  assign sel_data = (req_addr_i == A_DATA);

  assign soft_rst    = wr_acc && sel_ctrl && ctrl_q[CB_EN] && !wbyte[CB_EN];
  assign ctrl_norm   = wr_acc && sel_ctrl && !soft_rst;
  assign rsta_close  = ctrl_norm && wbyte[CB_MST] && wbyte[CB_RSTA] && addr_open_q;
  assign recv_launch = rd_acc && sel_data && ctrl_q[CB_MST] && addr_open_q && !ctrl_q[CB_TX];

  assign done_addr = x_done && (x_done_op == OP_START);
  assign done_send = x_done && (x_done_op == OP_SEND);
  assign done_recv = x_done && (x_done_op == OP_RECV);

  // command selection; at most one source per accepted access
  always_comb begin
    launch      = 1'b0;
    launch_op   = OP_START;
    launch_byte = '0;
    if (soft_rst && addr_open_q) begin
      launch    = 1'b1;
      launch_op = OP_STOP;
    end else if (ctrl_norm && addr_open_q && (!wbyte[CB_MST] || wbyte[CB_RSTA])) begin
      launch    = 1'b1;
      launch_op = OP_STOP;
    end else if (wr_acc && sel_data && ctrl_q[CB_EN] && ctrl_q[CB_MST]) begin
      launch      = 1'b1;
      launch_op   = addr_open_q ? OP_SEND : OP_START;
      launch_byte = wbyte;
    end else if (recv_launch) begin
      launch    = 1'b1;
      launch_op = OP_RECV;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= '0;
    end else if (wr_acc && sel_own) begin
      own_q <= wbyte & OWN_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q       <= '0;
      ctrl_q      <= '0;
      addr_open_q <= 1'b0;
      rdata_q     <= '0;
    end else if (soft_rst) begin
      div_q       <= '0;
      ctrl_q      <= '0;
      addr_open_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      if (wr_acc && sel_div) div_q <= wbyte & DIV_MASK;
      if (ctrl_norm) begin
        ctrl_q <= wbyte & CTRL_MASK;
        if (rsta_close) ctrl_q[CB_RSTA] <= 1'b0;
        if (!wbyte[CB_MST] || wbyte[CB_RSTA]) addr_open_q <= 1'b0;
      end
      if (done_addr && x_ack)  addr_open_q <= 1'b1;
      if (done_send && !x_ack) addr_open_q <= 1'b0;
      if (rd_acc && sel_data && ctrl_q[CB_MST] && !recv_launch) rdata_q <= 8'hFF;
      if (done_recv) rdata_q <= x_data;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_own)  rd_mux = own_q;
    if (sel_div)  rd_mux = div_q;
    if (sel_ctrl) rd_mux = ctrl_q;
    if (sel_sts)  rd_mux = sts;
    if (sel_data) rd_mux = ctrl_q[CB_MST] ? 8'hFF : rdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_q       <= '0;
    end else begin
      rsp_valid_q <= (rd_acc && !recv_launch) || done_recv;
      if (done_recv)                 rsp_q <= x_data;
      else if (rd_acc && !recv_launch) rsp_q <= rd_mux;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = {{(BUS_W-REG_W){1'b0}}, rsp_q};

  i2cm_xfer #(.BYTE_W(REG_W)) u_xfer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_i      (launch),
    .launch_op_i   (launch_op),
    .launch_byte_i (launch_byte),
    .bus_valid_o   (bus_valid_o),
    .bus_op_o      (x_op),
    .bus_byte_o    (x_byte),
    .bus_done_i    (bus_done_i),
    .bus_ack_i     (bus_ack_i),
    .bus_rdata_i   (bus_rdata_i),
    .busy_o        (x_busy),
    .done_o        (x_done),
    .done_op_o     (x_done_op),
    .done_ack_o    (x_ack),
    .done_data_o   (x_data)
  );
  assign bus_op_o   = x_op;
  assign bus_byte_o = x_byte;

  i2cm_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .en_i       (ctrl_q[CB_EN]),
    .ien_i      (ctrl_q[CB_IEN]),
    .raise_i    ((done_addr && x_ack) || (done_send && x_ack) || done_recv),
    .busy_set_i (ctrl_norm && wbyte[CB_MST]),
    .busy_clr_i (ctrl_norm && !wbyte[CB_MST]),
    .rxak_set_i ((done_addr || done_send) && !x_ack),
    .rxak_clr_i ((done_addr || done_send) && x_ack),
    .lost_i     (x_done && bus_lost_i),
    .wr_i       (wr_acc && sel_sts),
    .wdata_i    (wbyte),
    .status_o   (sts),
    .irq_o      (irq_o)
  );

  assert_soft_rst_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (ctrl_q == '0 && div_q == '0 && !addr_open_q && !irq_o));
  assert_own_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (own_q == $past(own_q)));
  assert_stall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> !req_ready_o);
  assert_plain_rsp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && !recv_launch) |=> rsp_valid_o);
  assert_disabled_data_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && sel_data && !ctrl_q[CB_EN]) |=> !bus_valid_o);
  assert_rsta_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsta_close |=> (!ctrl_q[CB_RSTA] && bus_valid_o && bus_op_o == 2'd3));
endmodule

// File: tb/tb_i2c_master_regs.sv
`timescale 1ns/1ps
module tb_i2c_master_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, bus_valid, irq;
  logic [15:0] rsp_rdata;
  logic [1:0]  bus_op;
  logic [7:0]  bus_byte;
  logic        bus_done = 1'b0, bus_ack = 1'b0, bus_lost = 1'b0;
  logic [7:0]  bus_rdata = '0;

  always #2 clk = ~clk;

  i2c_master_regs dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .bus_valid_o(bus_valid), .bus_op_o(bus_op), .bus_byte_o(bus_byte),
    .bus_done_i(bus_done), .bus_ack_i(bus_ack), .bus_lost_i(bus_lost),
    .bus_rdata_i(bus_rdata), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  int exp_rsp_q[$];
  string exp_rsp_tag[$];
  int exp_op_q[$];
  int exp_byte_q[$];
  string exp_op_tag[$];
  bit resp_ack = 1'b1, resp_lost = 1'b0;
  logic [7:0] resp_data = 8'h00;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // read-response monitor
  initial forever begin
    @(negedge clk);
    if (rsp_valid) begin
      if (exp_rsp_q.size() == 0) check(1'b0, "R1 unexpected response", int'(rsp_rdata), -1);
      else begin
        automatic int e = exp_rsp_q.pop_front();
        automatic string t = exp_rsp_tag.pop_front();
        check(int'(rsp_rdata) == e, t, int'(rsp_rdata), e);
      end
    end
  end

  // bus model and command monitor
  initial begin
    automatic int cnt = 0;
    automatic int cur = 0;
    forever begin
      @(negedge clk);
      bus_done = 1'b0; bus_ack = 1'b0; bus_lost = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          bus_done  = 1'b1;
          bus_ack   = (cur == 3) ? 1'b1 : resp_ack;
          bus_lost  = (cur == 3) ? 1'b0 : resp_lost;
          bus_rdata = resp_data;
        end
      end
      if (bus_valid) begin
        cur = int'(bus_op);
        cnt = 2;
        if (exp_op_q.size() == 0) check(1'b0, "R11 unexpected bus command", cur, -1);
        else begin
          automatic int eo = exp_op_q.pop_front();
          automatic int eb = exp_byte_q.pop_front();
          automatic string t = exp_op_tag.pop_front();
          check(cur == eo, t, cur, eo);
          if (eo <= 1) check(int'(bus_byte) == eb, {t, " byte"}, int'(bus_byte), eb);
        end
      end
    end
  end

  task automatic access(bit wr, logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    access(1'b1, a, d);
    wait_idle();
  endtask

  // plain read: answer must be present at the first falling edge after acceptance
  task automatic rd(logic [4:0] a, int e, string t);
    exp_rsp_q.push_back(e); exp_rsp_tag.push_back(t);
    access(1'b0, a, 16'h0);
    check(rsp_valid == 1'b1, {t, " latency"}, int'(rsp_valid), 1);
    wait_idle();
  endtask

  task automatic rd_bus(logic [4:0] a, int e, string t);
    exp_rsp_q.push_back(e); exp_rsp_tag.push_back(t);
    access(1'b0, a, 16'h0);
    wait_idle();
  endtask

  task automatic exp_op(int op, int b, string t);
    exp_op_q.push_back(op); exp_byte_q.push_back(b); exp_op_tag.push_back(t);
  endtask

  task automatic chk_irq(bit e, string t);
    @(negedge clk);
    check(irq == e, t, int'(irq), int'(e));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  localparam logic [4:0] OWN = 5'h00, DIV = 5'h04, CTL = 5'h08, STS = 5'h0C, DAT = 5'h10;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and decode
    rd(OWN, 0, "R1 own reset");
    rd(DIV, 0, "R1 div reset");
    rd(CTL, 0, "R1 ctrl reset");
    rd(STS, 0, "R1 status reset");
    rd(DAT, 0, "R1 data reset");
    rd(5'h14, 0, "R1 unmapped 0x14");
    chk_irq(1'b0, "R1 irq reset");
    // R12 masking
    wr(OWN, 16'h01FF);
    rd(OWN, 8'hFE, "R12 own mask");
    wr(DIV, 16'hABCD);
    rd(DIV, 8'h0D, "R12 div mask");
    wr(CTL, 16'hFF03);
    rd(CTL, 0, "R12 ctrl mask");
    wr(5'h02, 16'h00FF);
    rd(5'h02, 0, "R1 unaligned offset");
    // R10 disabled data write
    wr(DAT, 16'h00A4);
    rd(STS, 0, "R10 status after disabled write");
    wr(CTL, 16'h0020);
    rd(STS, 8'h20, "R5 busy with master set");
    wr(DAT, 16'h00A4);
    rd(STS, 8'h20, "R10 disabled master write ignored");
    rd(DAT, 8'hFF, "R9 master read with no address");
    wr(CTL, 16'h0000);
    rd(STS, 0, "R5 busy cleared");
    // enable, master, transmit
    wr(CTL, 16'h00F0);
    rd(STS, 8'h20, "R5 busy on master");
    resp_ack = 1'b0;
    exp_op(0, 8'h90, "R7 start nack");
    wr(DAT, 16'h0090);
    rd(STS, 8'h21, "R7 nack sets rxak");
    chk_irq(1'b0, "R7 no irq on nack");
    resp_ack = 1'b1;
    exp_op(0, 8'h90, "R7 start ack");
    wr(DAT, 16'h0090);
    rd(STS, 8'h22, "R7 ack clears rxak sets irq");
    chk_irq(1'b1, "R3 irq line raised");
    wr(STS, 16'h0012);
    rd(STS, 8'h22, "R4 write one no effect");
    wr(STS, 16'h0000);
    rd(STS, 8'h20, "R4 write zero clears irq");
    chk_irq(1'b0, "R4 irq line lowered");
    exp_op(1, 8'h5A, "R8 send ack");
    wr(DAT, 16'h005A);
    rd(STS, 8'h22, "R8 send ack irq");
    wr(STS, 16'h0000);
    resp_ack = 1'b0; resp_lost = 1'b1;
    exp_op(1, 8'h3C, "R8 send nack");
    exp_op(3, 0, "R8 end after nack");
    wr(DAT, 16'h003C);
    rd(STS, 8'h31, "R8 nack rxak and R4 lost flag");
    chk_irq(1'b0, "R8 no irq on nack");
    resp_ack = 1'b1; resp_lost = 1'b0;
    exp_op(0, 8'h91, "R8 address closed after nack");
    wr(DAT, 16'h0091);
    rd(STS, 8'h32, "R7 reopen");
    wr(STS, 16'h0002);
    rd(STS, 8'h22, "R4 lost cleared irq kept");
    wr(STS, 16'h0000);
    // R9 receive paths
    rd(DAT, 8'hFF, "R9 read with transmit set");
    wr(CTL, 16'h00E0);
    resp_data = 8'h6B;
    exp_op(2, 0, "R9 receive command");
    rd_bus(DAT, 8'h6B, "R9 received byte");
    rd(STS, 8'h22, "R9 receive raises irq");
    wr(STS, 16'h0000);
    // R6 repeated start
    exp_op(3, 0, "R6 end on repeated start");
    wr(CTL, 16'h00E4);
    rd(CTL, 8'hE0, "R6 rsta self-clears");
    exp_op(0, 8'h20, "R6 next write is address");
    wr(DAT, 16'h0020);
    rd(STS, 8'h22, "R6 reopened");
    wr(STS, 16'h0000);
    // R5 leaving master ends transfer
    exp_op(3, 0, "R5 end on master clear");
    wr(CTL, 16'h00C0);
    rd(STS, 0, "R5 busy cleared on master clear");
    rd(DAT, 8'h6B, "R9 non-master read returns stored byte");
    // R3 gating
    wr(CTL, 16'h00A0);
    exp_op(0, 8'h44, "R3 start without ien");
    wr(DAT, 16'h0044);
    rd(STS, 8'h20, "R3 no irq flag without ien");
    chk_irq(1'b0, "R3 irq line low without ien");
    // R2 soft reset with open address
    exp_op(3, 0, "R2 end on soft reset");
    wr(CTL, 16'h0000);
    rd(OWN, 8'hFE, "R2 own kept");
    rd(DIV, 0, "R2 div cleared");
    rd(CTL, 0, "R2 ctrl cleared");
    rd(STS, 0, "R2 status cleared");
    rd(DAT, 0, "R2 stored byte cleared");
    wr(CTL, 16'h00A0);
    exp_op(0, 8'h44, "R2 address closed by soft reset");
    wr(DAT, 16'h0044);
    repeat (4) @(negedge clk);
    check(exp_op_q.size() == 0, "R11 pending commands", exp_op_q.size(), 0);
    check(exp_rsp_q.size() == 0, "R1 pending responses", exp_rsp_q.size(), 0);
    finish_run();
  end
endmodule